// File: doc/BRIEF.md
# Up/Down Timer with Toggle and Match PWM

A free-running timer that counts down from a programmable start value or counts up toward all-ones. Each time it reaches its terminal value (zero when counting down, all-ones when counting up) it produces a one-cycle timeout event. On that event it restarts: a down count reloads the start value, and an up count begins again at zero. Every timeout event sets a sticky flag. The flag stays set until a clear strobe arrives.

One PWM pin is derived from the count and works in one of two modes. In toggle mode the pin flips at every timeout. In match mode the pin leaves its idle level when the count equals a compare value and returns to idle at the next timeout. A one-bit control picks whether the idle level is low or high. An event input, when allowed by its enable, forces the counter back to its start value. A status output reports that such a forced restart has just been applied.

Top module: `updown_pwm_timer`

## Requirements
- R1: Counting down (`count_up`=0) while enabled, the count falls by one per clock. A clock edge taken while the count is zero loads `reload_val` instead, and that edge is a timeout event.
- R2: Counting up (`count_up`=1) while enabled, the count rises by one per clock. A clock edge taken while the count is all-ones (0xFFFF) loads zero instead, and that edge is a timeout event.
- R3: `timeout_flag` becomes 1 on the edge of a timeout event. It stays 1 until an edge that sees `clr_flag`=1 with no timeout event in the same cycle. A timeout event in the same cycle as `clr_flag` leaves the flag set.
- R4: While `enable`=0, each edge loads `reload_val` into the count. `pwm_out` is at the idle level in that same cycle, with no clock delay.
- R5: With `match_mode`=0 (toggle mode), `pwm_out` starts at the idle level when the timer is enabled and inverts on every timeout event.
- R6: With `match_mode`=1 (match mode), `pwm_out` leaves the idle level on the edge that sees the count equal to `match_val`. It returns to the idle level on the edge of the next timeout event.
- R7: In match mode, if the compare value coincides with a timeout event in the same cycle, or is never reached before the timeout, `pwm_out` stays at the idle level.
- R8: `idle_high`=0 gives an idle level of 0 and `idle_high`=1 gives an idle level of 1. The active level is the inverse of the idle level.
- R9: While enabled with `evt_rst_en`=1, an edge that sees `evt_in`=1 loads the start value (`reload_val` when counting down, zero when counting up). `evt_busy` is 1 during the cycle that follows. With `evt_rst_en`=0 the event has no effect and `evt_busy` stays 0.
- R10: While `rst_n`=0, the count is 0, `timeout_flag` and `evt_busy` are 0, and `pwm_out` is at the idle level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the timer; 0 holds it at its preset and idles the PWM |
| count_up | input | 1 | 1 counts up, 0 counts down |
| reload_val | input | WIDTH | Start value for down counting and for the disabled preset |
| match_val | input | WIDTH | Compare value for match mode |
| match_mode | input | 1 | 0 toggle mode, 1 match mode |
| idle_high | input | 1 | PWM idle level |
| evt_rst_en | input | 1 | Allows `evt_in` to restart the counter |
| evt_in | input | 1 | Event that restarts the counter |
| clr_flag | input | 1 | Clears the timeout flag |
| count | output | WIDTH | Live count |
| timeout_flag | output | 1 | Sticky timeout flag |
| evt_busy | output | 1 | An event restart was applied on the last edge |
| pwm_out | output | 1 | PWM pin |

## Verification
Count, flag, busy status and the PWM active state are registers, so each one shows the result of a cycle's inputs one edge later. The exception is the idle override on `enable`, which reaches `pwm_out` without any clock delay. The bench changes inputs on falling edges and samples on falling edges. It therefore reads every registered result exactly N rising edges after the stimulus. It derives N by hand from the count sequence, for example a period of reload+1 edges when counting down. The idle override is checked a few nanoseconds after `enable` falls, before the next rising edge.

// File: rtl/updown_pwm_timer.sv
module updown_pwm_timer #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             count_up,
  input  logic [WIDTH-1:0] reload_val,
  input  logic [WIDTH-1:0] match_val,
  input  logic             match_mode,
  input  logic             idle_high,
  input  logic             evt_rst_en,
  input  logic             evt_in,
  input  logic             clr_flag,
  output logic [WIDTH-1:0] count,
  output logic             timeout_flag,
  output logic             evt_busy,
  output logic             pwm_out
);

  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ZERO     = {WIDTH{1'b0}};

  logic [WIDTH-1:0] cnt_q;
  logic             flag_q;
  logic             busy_q;
  logic             act_q;

  wire              at_end   = count_up ? (cnt_q == ALL_ONES) : (cnt_q == ZERO);
  wire              tick_end = enable && at_end;
  wire              evt_hit  = enable && evt_rst_en && evt_in;
  wire              cmp_hit  = enable && (cnt_q == match_val);
  wire [WIDTH-1:0]  restart  = count_up ? ZERO : reload_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= ZERO;
    end else if (!enable) begin
      cnt_q <= reload_val;
    end else if (tick_end || evt_hit) begin
      cnt_q <= restart;
    end else if (count_up) begin
      cnt_q <= cnt_q + 1'b1;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      busy_q <= evt_hit;
      if (tick_end)      flag_q <= 1'b1;
      else if (clr_flag) flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
    end else if (!enable) begin
      act_q <= 1'b0;
    end else if (match_mode) begin
      if (tick_end)     act_q <= 1'b0;
      else if (cmp_hit) act_q <= 1'b1;
    end else if (tick_end) begin
      act_q <= ~act_q;
    end
  end

  assign count        = cnt_q;
  assign timeout_flag = flag_q;
  assign evt_busy     = busy_q;
  assign pwm_out      = idle_high ^ (enable & act_q);

endmodule

// File: rtl/updown_pwm_timer_chk.sv
module updown_pwm_timer_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             count_up,
  input logic [WIDTH-1:0] reload_val,
  input logic [WIDTH-1:0] match_val,
  input logic             match_mode,
  input logic             idle_high,
  input logic             evt_rst_en,
  input logic             evt_in,
  input logic             clr_flag,
  input logic [WIDTH-1:0] count,
  input logic             timeout_flag,
  input logic             evt_busy,
  input logic             pwm_out
);

  wire term = count_up ? (&count) : (count == '0);
  wire evt  = evt_rst_en && evt_in;

  p_down_reload_r1: assert property (@(posedge clk) disable iff (!rst_n)
    enable && !count_up && count == '0 |=> count == $past(reload_val));

  p_down_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    enable && !count_up && count != '0 && !evt |=> count == $past(count) - 1'b1);

  p_up_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    enable && count_up && (&count) |=> count == '0);

  p_flag_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    enable && term |=> timeout_flag);

  p_flag_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_flag && !clr_flag |=> timeout_flag);

  p_preset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> count == $past(reload_val));

  p_idle_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> pwm_out == idle_high);

  p_match_end_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    enable && match_mode && term |=> pwm_out == idle_high);

  p_evt_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    enable && evt |=> evt_busy);

  p_evt_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_rst_en |=> !evt_busy);

endmodule

bind updown_pwm_timer updown_pwm_timer_chk #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .enable(enable), .count_up(count_up),
  .reload_val(reload_val), .match_val(match_val), .match_mode(match_mode),
  .idle_high(idle_high), .evt_rst_en(evt_rst_en), .evt_in(evt_in),
  .clr_flag(clr_flag), .count(count), .timeout_flag(timeout_flag),
  .evt_busy(evt_busy), .pwm_out(pwm_out)
);

// File: tb/updown_pwm_timer_tb_top.sv
module updown_pwm_timer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0, count_up = 1'b0, match_mode = 1'b0, idle_high = 1'b0;
  logic        evt_rst_en = 1'b0, evt_in = 1'b0, clr_flag = 1'b0;
  logic [15:0] reload_val = '0, match_val = '0;
  logic [15:0] count;
  logic        timeout_flag, evt_busy, pwm_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  updown_pwm_timer #(.WIDTH(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .count_up(count_up),
    .reload_val(reload_val), .match_val(match_val), .match_mode(match_mode),
    .idle_high(idle_high), .evt_rst_en(evt_rst_en), .evt_in(evt_in),
    .clr_flag(clr_flag), .count(count), .timeout_flag(timeout_flag),
    .evt_busy(evt_busy), .pwm_out(pwm_out)
  );

  typedef struct packed {
    logic        up;
    logic        mode;
    logic        idle;
    logic [15:0] rld;
    logic [15:0] mtc;
    logic [7:0]  n;
    logic [15:0] ecnt;
    logic        eflag;
    logic        epwm;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 1'b0, 16'd4,      16'd0,      8'd3,  16'd1,      1'b0, 1'b0}, // R1 mid-count
    '{1'b0, 1'b0, 1'b0, 16'd4,      16'd0,      8'd5,  16'd4,      1'b1, 1'b1}, // R1 R5 first timeout
    '{1'b0, 1'b0, 1'b0, 16'd4,      16'd0,      8'd10, 16'd4,      1'b1, 1'b0}, // R5 two toggles
    '{1'b0, 1'b0, 1'b1, 16'd4,      16'd0,      8'd5,  16'd4,      1'b1, 1'b0}, // R8 idle high
    '{1'b0, 1'b1, 1'b0, 16'd4,      16'd2,      8'd3,  16'd1,      1'b0, 1'b1}, // R6 asserted on match
    '{1'b0, 1'b1, 1'b0, 16'd4,      16'd2,      8'd5,  16'd4,      1'b1, 1'b0}, // R6 released on timeout
    '{1'b0, 1'b1, 1'b0, 16'd4,      16'd0,      8'd6,  16'd3,      1'b1, 1'b0}, // R7 coincident
    '{1'b0, 1'b1, 1'b1, 16'd4,      16'd9,      8'd3,  16'd1,      1'b0, 1'b1}, // R7 never matched
    '{1'b1, 1'b0, 1'b0, 16'hFFFD,   16'd0,      8'd2,  16'hFFFF,   1'b0, 1'b0}, // R2 at full scale
    '{1'b1, 1'b0, 1'b0, 16'hFFFD,   16'd0,      8'd3,  16'h0000,   1'b1, 1'b1}, // R2 wrap
    '{1'b1, 1'b0, 1'b0, 16'hFFFD,   16'd0,      8'd5,  16'h0002,   1'b1, 1'b1}, // R2 after wrap
    '{1'b1, 1'b1, 1'b0, 16'hFFF0,   16'hFFF8,   8'd9,  16'hFFF9,   1'b0, 1'b1}  // R6 up match
  };

  task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R10 reset state
    idle_high = 1'b1;
    repeat (3) @(negedge clk);
    check("R10", "count", count, 16'd0);
    check("R10", "flag", {15'd0, timeout_flag}, 16'd0);
    check("R10", "busy", {15'd0, evt_busy}, 16'd0);
    check("R10", "pwm", {15'd0, pwm_out}, 16'd1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      enable = 1'b0; clr_flag = 1'b1;
      count_up = VEC[i].up; match_mode = VEC[i].mode; idle_high = VEC[i].idle;
      reload_val = VEC[i].rld; match_val = VEC[i].mtc;
      @(negedge clk);
      check("R4", "preset", count, VEC[i].rld);
      clr_flag = 1'b0; enable = 1'b1;
      repeat (int'(VEC[i].n)) @(negedge clk);
      check(VEC[i].up ? "R2" : "R1", "count", count, VEC[i].ecnt);
      check("R3", "flag", {15'd0, timeout_flag}, {15'd0, VEC[i].eflag});
      check(VEC[i].mode ? "R6" : "R5", "pwm", {15'd0, pwm_out}, {15'd0, VEC[i].epwm});
    end

    // R4 disabling forces idle at once (last vector left pwm active)
    enable = 1'b0;
    #2;
    check("R4", "pwm idle low", {15'd0, pwm_out}, 16'd0);
    idle_high = 1'b1;
    #1;
    check("R8", "pwm idle high", {15'd0, pwm_out}, 16'd1);

    // R3 timeout beats clear in the same cycle, then clear alone works
    count_up = 1'b0; match_mode = 1'b0; idle_high = 1'b0; reload_val = 16'd1; clr_flag = 1'b1;
    @(negedge clk);
    clr_flag = 1'b0; enable = 1'b1;
    @(negedge clk);
    check("R1", "count at zero", count, 16'd0);
    clr_flag = 1'b1;
    @(negedge clk);
    check("R3", "set wins over clear", {15'd0, timeout_flag}, 16'd1);
    @(negedge clk);
    check("R3", "cleared", {15'd0, timeout_flag}, 16'd0);
    clr_flag = 1'b0;

    // R9 event restart counting down
    enable = 1'b0; reload_val = 16'd20;
    @(negedge clk);
    enable = 1'b1; evt_rst_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R9", "pre-event count", count, 16'd17);
    evt_in = 1'b1;
    @(negedge clk);
    evt_in = 1'b0;
    check("R9", "down restart", count, 16'd20);
    check("R9", "busy", {15'd0, evt_busy}, 16'd1);
    @(negedge clk);
    check("R9", "busy drops", {15'd0, evt_busy}, 16'd0);
    check("R9", "counts on", count, 16'd19);

    // R9 event ignored without its enable
    evt_rst_en = 1'b0; evt_in = 1'b1;
    @(negedge clk);
    evt_in = 1'b0;
    check("R9", "ignored count", count, 16'd18);
    check("R9", "ignored busy", {15'd0, evt_busy}, 16'd0);

    // R9 event restart counting up goes to zero
    enable = 1'b0; count_up = 1'b1; reload_val = 16'h0100;
    @(negedge clk);
    enable = 1'b1; evt_rst_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R2", "up count", count, 16'h0103);
    evt_in = 1'b1;
    @(negedge clk);
    evt_in = 1'b0;
    check("R9", "up restart", count, 16'h0000);
    check("R9", "up no timeout", {15'd0, timeout_flag}, 16'd0);

    finish_run();
  end

endmodule